// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block gathers interrupt requests from a parameterised set of devices and decides, once per instruction, whether the processor must be interrupted. Each device is tied at build time to one of eight priority levels (0 lowest, 7 highest). Software enables or disables each device through a one-bit-per-device mask register loaded over a single-cycle write port. A cleared mask bit blocks that device.

At every fetch-boundary strobe the arbiter finds the unmasked, requesting device with the highest level. If several share that level, the lowest index wins. The arbiter raises its interrupt only when that level is strictly greater than the priority of the task now running. The decision, the winning index and its level are registered on the strobe and held unchanged until the next strobe.

The decision is held by a two-state machine. GATE_QUIET means no interrupt is presented. GATE_RAISED means an interrupt is presented. These transitions occur on a strobe:
- QUIET to RAISED (`raise`) when a candidate beats the task level.
- RAISED to RAISED (`repick`) when a candidate still beats it; index and level are refreshed.
- RAISED to QUIET (`drop`) when none does.
- QUIET to QUIET (`stay_quiet`) when none does.

Without a strobe, the state machine holds its state (`hold`).

With the default parameters there are 8 devices, and their levels are, by index 0..7: 2, 5, 5, 7, 0, 3, 7, 1.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset `irq_o` is 0, `win_idx_o` is 0 and `win_lvl_o` is 0. The mask register resets to all zeros, so no device can interrupt until it is enabled.
- R2: A device whose mask bit is 0 never wins and never causes `irq_o`, whatever its request or level.
- R3: On a strobe, the candidate is the requesting, unmasked device with the highest level. `win_lvl_o` reports that device's level.
- R4: When several requesting, unmasked devices share the highest level, the one with the lowest index wins.
- R5: The candidate raises `irq_o` only if its level is strictly greater than `cur_pri`. An equal level does not interrupt.
- R6: `irq_o`, `win_idx_o` and `win_lvl_o` change only at a clock edge where `fetch_stb` is 1. At any other edge they keep their values, even when requests, the mask or `cur_pri` change.
- R7: When `mask_we` is 1 at an edge, the mask register takes `mask_wdata` at that edge. A strobe at the same edge is judged with the mask value from before the write.
- R8: At a strobe where no candidate beats `cur_pri`, `irq_o` becomes 0 and both `win_idx_o` and `win_lvl_o` become 0.
- R9: A device tied to level 0 can never raise `irq_o`, because no task level is below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Request line per device, level sensitive |
| mask_we | input | 1 | Load the mask register this cycle |
| mask_wdata | input | N_DEV | New mask value, bit i enables device i |
| cur_pri | input | 3 | Priority level of the running task |
| fetch_stb | input | 1 | Marks the start of an instruction cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| win_idx_o | output | $clog2(N_DEV) | Index of the granted device, 0 when idle |
| win_lvl_o | output | 3 | Level of the granted device, 0 when idle |

## Verification
A mask write and a fetch-boundary strobe can land on the same clock edge. The arbiter must then decide with the old mask while the new value is stored for later strobes. The bench provokes this in both directions: it enables a high-level device and disables the current winner at the very edge of a strobe. It then strobes again one cycle later. A reference model compares all three outputs with its own prediction after every edge. The model updates its mask only after it has evaluated the strobe, so a design that uses the new mask at the shared edge differs in that cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [0:0] {
        GATE_QUIET  = 1'b0,
        GATE_RAISED = 1'b1
    } gate_state_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N_DEV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_DEV-1:0] wr_data,
    output logic [N_DEV-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_level_tree.sv
module irq_level_tree
    import irq_arb_pkg::*;
#(
    parameter int                     N_DEV      = 8,
    parameter logic [N_DEV*LVL_W-1:0] DEV_LEVELS = '0,
    parameter int                     IDX_W      = 3
) (
    input  logic [N_DEV-1:0] req,
    input  logic [N_DEV-1:0] mask,
    output logic             found,
    output logic [IDX_W-1:0] best_idx,
    output lvl_t             best_lvl
);
    lvl_t             dev_lvl  [N_DEV];
    logic [N_DEV-1:0] eligible;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        assign dev_lvl[g]  = DEV_LEVELS[g*LVL_W +: LVL_W];
        assign eligible[g] = req[g] & mask[g];
    end

    // Scan upward; a later device replaces the best only on a strictly
    // higher level, so ties settle on the lowest index.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_lvl = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (eligible[i] && (!found || dev_lvl[i] > best_lvl)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_lvl = dev_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_fetch_gate.sv
module irq_fetch_gate
    import irq_arb_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_stb,
    input  lvl_t             cur_pri,
    input  logic             cand_found,
    input  logic [IDX_W-1:0] cand_idx,
    input  lvl_t             cand_lvl,
    output logic             irq_o,
    output logic [IDX_W-1:0] win_idx_o,
    output lvl_t             win_lvl_o
);
    gate_state_e state_q, state_d;
    logic        beats;

    assign beats = cand_found && (cand_lvl > cur_pri);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_QUIET:  if (fetch_stb && beats)  state_d = GATE_RAISED;
            GATE_RAISED: if (fetch_stb && !beats) state_d = GATE_QUIET;
            default:     state_d = GATE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_idx_o <= '0;
            win_lvl_o <= '0;
        end else if (fetch_stb) begin
            if (beats) begin
                win_idx_o <= cand_idx;
                win_lvl_o <= cand_lvl;
            end else begin
                win_idx_o <= '0;
                win_lvl_o <= '0;
            end
        end
    end

    assign irq_o = (state_q == GATE_RAISED);

    // R6
    hold_between_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stb |=> ($stable(irq_o) && $stable(win_idx_o) && $stable(win_lvl_o)));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (win_idx_o == '0 && win_lvl_o == '0));

    // R5
    top_task_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && cur_pri == 3'd7) |=> !irq_o);

    // R9
    nonzero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_lvl_o != '0));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int                     N_DEV      = 8,
    parameter logic [N_DEV*LVL_W-1:0] DEV_LEVELS = {3'd1, 3'd7, 3'd3, 3'd0,
                                                    3'd7, 3'd5, 3'd5, 3'd2},
    localparam int                    IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] req_i,
    input  logic             mask_we,
    input  logic [N_DEV-1:0] mask_wdata,
    input  logic [2:0]       cur_pri,
    input  logic             fetch_stb,
    output logic             irq_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic [2:0]       win_lvl_o
);
    logic [N_DEV-1:0] mask_q;
    logic             cand_found;
    logic [IDX_W-1:0] cand_idx;
    lvl_t             cand_lvl;

    irq_mask_reg #(.N_DEV(N_DEV)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_data (mask_wdata),
        .mask_q  (mask_q)
    );

    irq_level_tree #(
        .N_DEV      (N_DEV),
        .DEV_LEVELS (DEV_LEVELS),
        .IDX_W      (IDX_W)
    ) u_tree (
        .req      (req_i),
        .mask     (mask_q),
        .found    (cand_found),
        .best_idx (cand_idx),
        .best_lvl (cand_lvl)
    );

    irq_fetch_gate #(.IDX_W(IDX_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_stb  (fetch_stb),
        .cur_pri    (cur_pri),
        .cand_found (cand_found),
        .cand_idx   (cand_idx),
        .cand_lvl   (cand_lvl),
        .irq_o      (irq_o),
        .win_idx_o  (win_idx_o),
        .win_lvl_o  (win_lvl_o)
    );

    // R2
    masked_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && mask_q == '0) |=> !irq_o);
endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    int dev_level [N] = '{2, 5, 5, 7, 0, 3, 7, 1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic [2:0]   cur_pri = '0;
    logic         fetch_stb = 1'b0;
    logic         irq_o;
    logic [2:0]   win_idx_o;
    logic [2:0]   win_lvl_o;

    int checks = 0;
    int fails = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state
    int     m_mask;
    int     m_irq, m_idx, m_lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .cur_pri(cur_pri), .fetch_stb(fetch_stb),
        .irq_o(irq_o), .win_idx_o(win_idx_o), .win_lvl_o(win_lvl_o));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = 0; m_irq = 0; m_idx = 0; m_lvl = 0;
        end else begin
            if (fetch_stb) begin
                int bi, bl;
                bi = -1; bl = -1;
                for (int i = 0; i < N; i++)
                    if (req_i[i] && m_mask[i] && dev_level[i] > bl) begin
                        bi = i; bl = dev_level[i];
                    end
                if (bi >= 0 && bl > int'(cur_pri)) begin
                    m_irq = 1; m_idx = bi; m_lvl = bl;
                end else begin
                    m_irq = 0; m_idx = 0; m_lvl = 0;
                end
            end
            if (mask_we) m_mask = int'(mask_wdata);
        end
    end

    task automatic compare();
        checks++;
        if (int'(irq_o) != m_irq || int'(win_idx_o) != m_idx || int'(win_lvl_o) != m_lvl) begin
            fails++;
            $display("FAIL %s: irq/idx/lvl actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, irq_o, win_idx_o, win_lvl_o, m_irq, m_idx, m_lvl);
        end
    endtask

    task automatic step(input bit stb, input logic [N-1:0] rq, input bit we,
                        input logic [N-1:0] wd, input int pri);
        fetch_stb  = stb;
        req_i      = rq;
        mask_we    = we;
        mask_wdata = wd;
        cur_pri    = 3'(pri);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; compare();
        step(1, 8'hFF, 0, 8'h00, 0);            // R1: mask resets closed
        step(0, 8'h00, 1, 8'hFF, 0);            // open all
        tag = "R2";
        step(0, 8'h00, 1, 8'hB7, 0);            // block dev3 and dev6
        step(1, 8'h48, 0, 8'h00, 0);            // only masked level-7 devices ask
        step(1, 8'h4A, 0, 8'h00, 0);            // dev1 unmasked wins at 5
        tag = "R3";
        step(0, 8'h00, 1, 8'hFF, 0);
        step(1, 8'hA1, 0, 8'h00, 0);            // dev0 2, dev5 3, dev7 1 -> dev5
        step(1, 8'h89, 0, 8'h00, 1);            // dev3 level 7
        tag = "R4";
        step(1, 8'h06, 0, 8'h00, 0);            // dev1 vs dev2 at 5 -> dev1
        step(1, 8'h48, 0, 8'h00, 0);            // dev3 vs dev6 at 7 -> dev3
        step(1, 8'h44, 0, 8'h00, 0);            // dev2 5 vs dev6 7 -> dev6
        tag = "R5";
        step(1, 8'h02, 0, 8'h00, 5);            // equal: no irq
        step(1, 8'h02, 0, 8'h00, 4);            // one below: irq
        step(1, 8'h08, 0, 8'h00, 7);            // top task blocks all
        tag = "R6";
        step(1, 8'h08, 0, 8'h00, 0);
        step(0, 8'h00, 0, 8'h00, 7);
        step(0, 8'h02, 1, 8'h00, 0);
        step(0, 8'hFF, 0, 8'h00, 3);
        tag = "R7";
        step(0, 8'h00, 1, 8'h02, 0);            // only dev1
        step(1, 8'h0A, 1, 8'h08, 0);            // same edge: old mask -> dev1
        step(1, 8'h0A, 0, 8'h00, 0);            // new mask -> dev3
        step(1, 8'h0A, 1, 8'h02, 0);            // same edge: old mask -> dev3
        step(1, 8'h0A, 0, 8'h00, 0);            // -> dev1
        tag = "R8";
        step(1, 8'h02, 0, 8'h00, 0);
        step(1, 8'h00, 0, 8'h00, 0);            // nothing pending -> cleared
        step(0, 8'h00, 1, 8'hFF, 0);
        tag = "R9";
        step(1, 8'h10, 0, 8'h00, 0);            // level-0 device at task 0
        step(1, 8'h90, 0, 8'h00, 0);            // dev7 level 1 takes it
        step(1, 8'h10, 0, 8'h00, 0);
        tag = "R3";
        for (int k = 0; k < 3000; k++)
            step(1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 3) == 0),
                 8'($urandom), $urandom_range(0, 7));
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule